// File: doc/BRIEF.md
# Two-Stage Sync Pattern Detector

This block watches a serial chip stream, one chip per strobe from an upstream clock-recovery stage, and recognises the start of a telegram that has two parts. The first part is a lead pattern. After it comes a gap of configured length, during which the line sits at one level. Once the gap has passed, a trailer pattern has to arrive inside a bounded window. When the gap ends, the block asks the clock recovery to re-synchronise. If the trailer arrives in time, the block reports a valid telegram and then stays idle until it is re-armed. If the window closes first, the block goes back to hunting for the lead pattern.

Positions are counted in strobes, so they follow the chip rate that was in effect before the gap. Both patterns are compared on the most recent chips held in one shared shift register. This register is zeroed when the gap ends, so the trailer comparison starts from a known all-zero history.

Top module: `sync2_detect`

## Requirements
- R1: A synchronous active-high `rst` drives all outputs low and clears the position counter and the chip history. After reset, only chips strobed after reset can form a lead match.
- R2: In the hunt state, each strobe shifts `chip_i` in as chip 0, so chip k strobes ago sits at bit k. When bits `len_a_i`-1..0 of the history equal the same bits of `pat_a_i` (length 1..16), `match_a_o` is high for exactly the cycle after that strobe.
- R3: After a lead match, the next `gap_len_i` strobes (gap_len_i at least 1) are counted and their chip values are ignored. `resync_o` is high for the cycle after the strobe that carries gap chip number `gap_len_i`.
- R4: The chip history is zeroed when the gap ends. Chips at positions gap+1 through gap+OFS-1, counted from the first gap chip, are neither shifted in nor compared.
- R5: From position gap+OFS (OFS defaults to 6) through position gap+`len_b_i`+11 inclusive, each chip is shifted in and the last `len_b_i` chips are compared with `pat_b_i`. On a hit, `tvalid_o` is high for the cycle after that strobe.
- R6: Because the history starts from zero, a trailer pattern of all zeros matches on the very first compared chip when that chip is 0. Configurations should therefore set the oldest trailer chip (bit `len_b_i`-1) to 1.
- R7: If no trailer hit occurs by position gap+`len_b_i`+11, the block clears the history and hunts for the lead pattern from the next strobe on.
- R8: After `tvalid_o`, no output rises until `rearm_i` is pulsed. `rearm_i` then returns the block to the hunt state with a cleared history. `rearm_i` has no effect in any other state.
- R9: At most one of the three outputs is high in any cycle, and an output is high only in the cycle after a strobe. Cycles without a strobe do not advance anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_i | input | 1 | Recovered chip value |
| chip_vld_i | input | 1 | Strobe, one per chip |
| rearm_i | input | 1 | Leave the held state after a valid telegram |
| pat_a_i | input | PAT_W | Lead pattern, bit 0 = newest chip |
| len_a_i | input | LEN_W | Lead pattern length, 1..PAT_W |
| pat_b_i | input | PAT_W | Trailer pattern, bit 0 = newest chip |
| len_b_i | input | LEN_W | Trailer pattern length, 1..PAT_W |
| gap_len_i | input | GAP_W | Gap length in chips, at least 1 |
| match_a_o | output | 1 | One-cycle pulse on a lead match |
| resync_o | output | 1 | One-cycle re-synchronisation request at gap end |
| tvalid_o | output | 1 | One-cycle telegram-valid pulse |

## Verification
The hardest behaviour to reach from the ports is the exact edges of the trailer window. A trailer that completes on the last allowed chip must be accepted, and one that completes a single chip later must be refused. The skipped chips just after the gap must also stay invisible. To reach these cases, the stimulus builds whole telegrams with a counted run of filler chips after the gap, chosen so that the pattern ends exactly on the window boundary or one chip past it. In one case the filler ends with the trailer's opening chips, so a design that compared too early would report a hit. Random streams with short patterns then push the detector through many timeouts, re-arms and back-to-back lead matches. A chip-by-chip bench model predicts every pulse.

// File: rtl/sync2_pkg.sv
package sync2_pkg;

  // Chips past (gap + trailer length) at which the trailer window closes.
  localparam int WIN_TAIL = 11;

  typedef enum logic [2:0] {
    ST_SEARCH_A,
    ST_GAP,
    ST_WAIT_WIN,
    ST_SEARCH_B,
    ST_HOLD
  } sync_state_e;

  // First chip position (counted from the first gap chip) that is compared.
  function automatic int win_first(input int gap, input int ofs);
    return gap + ofs;
  endfunction

  // Last chip position on which a trailer hit is still accepted.
  function automatic int win_last(input int gap, input int len_b);
    return gap + len_b + WIN_TAIL;
  endfunction

endpackage

// File: rtl/sync2_shreg.sv
module sync2_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);

  assign nxt = {q[W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (shift) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/sync2_cmp.sv
module sync2_cmp #(
  parameter int W     = 16,
  parameter int LEN_W = 5
) (
  input  logic [W-1:0]     win,
  input  logic [W-1:0]     pat,
  input  logic [LEN_W-1:0] len,
  output logic             hit
);

  logic [W-1:0] diff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = (win[i] ^ pat[i]) && (i < int'(len));
  end

  assign hit = ~|diff;

endmodule

// File: rtl/sync2_ctrl.sv
module sync2_ctrl
  import sync2_pkg::*;
#(
  parameter int GAP_W = 8,
  parameter int LEN_W = 5,
  parameter int OFS   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             rearm,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [LEN_W-1:0] len_b,
  output logic             shift_en,
  output logic             clr,
  output logic             match_a,
  output logic             resync,
  output logic             tvalid
);

  localparam int POS_W = GAP_W + LEN_W + 2;

  sync_state_e      st;
  logic [POS_W-1:0] pos, pos_nx, wstart, wstop;
  logic             in_win, at_end, gap_done, comparing;
  logic             ev_a_hit, ev_gap_end, ev_b_hit, ev_timeout;

  assign wstart = POS_W'(win_first(int'(gap_len), OFS));
  assign wstop  = POS_W'(win_last(int'(gap_len), int'(len_b)));

  always_comb begin
    pos_nx     = pos + POS_W'(1);
    in_win     = pos_nx >= wstart;
    at_end     = pos_nx >= wstop;
    gap_done   = pos_nx >= POS_W'(gap_len);
    comparing  = vld && (st == ST_WAIT_WIN || st == ST_SEARCH_B) && in_win;
    ev_a_hit   = vld && (st == ST_SEARCH_A) && hit_a;
    ev_gap_end = vld && (st == ST_GAP) && gap_done;
    ev_b_hit   = comparing && hit_b;
    ev_timeout = comparing && !hit_b && at_end;
    shift_en   = (vld && st == ST_SEARCH_A) || comparing;
    clr        = ev_gap_end || ev_timeout || (st == ST_HOLD && rearm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SEARCH_A;
      pos     <= '0;
      match_a <= 1'b0;
      resync  <= 1'b0;
      tvalid  <= 1'b0;
    end else begin
      match_a <= ev_a_hit;
      resync  <= ev_gap_end;
      tvalid  <= ev_b_hit;
      case (st)
        ST_SEARCH_A: begin
          if (ev_a_hit) begin
            st  <= ST_GAP;
            pos <= '0;
          end
        end
        ST_GAP: begin
          if (vld) begin
            pos <= pos_nx;
            if (gap_done) st <= ST_WAIT_WIN;
          end
        end
        ST_WAIT_WIN, ST_SEARCH_B: begin
          if (vld) begin
            pos <= pos_nx;
            if (ev_b_hit) begin
              st <= ST_HOLD;
            end else if (ev_timeout) begin
              st  <= ST_SEARCH_A;
              pos <= '0;
            end else if (in_win) begin
              st <= ST_SEARCH_B;
            end
          end
        end
        ST_HOLD: begin
          if (rearm) begin
            st  <= ST_SEARCH_A;
            pos <= '0;
          end
        end
        default: st <= ST_SEARCH_A;
      endcase
    end
  end

endmodule

// File: rtl/sync2_detect.sv
module sync2_detect #(
  parameter int PAT_W = 16,
  parameter int GAP_W = 8,
  parameter int OFS   = 6,
  parameter int LEN_W = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_i,
  input  logic             chip_vld_i,
  input  logic             rearm_i,
  input  logic [PAT_W-1:0] pat_a_i,
  input  logic [LEN_W-1:0] len_a_i,
  input  logic [PAT_W-1:0] pat_b_i,
  input  logic [LEN_W-1:0] len_b_i,
  input  logic [GAP_W-1:0] gap_len_i,
  output logic             match_a_o,
  output logic             resync_o,
  output logic             tvalid_o
);

  // Named internal events between the history, the comparators and the FSM.
  logic [PAT_W-1:0] hist_q, hist_nxt;
  logic             hit_a_w, hit_b_w, shift_w, clr_w;

  sync2_shreg #(.W(PAT_W)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_w),
    .shift (shift_w),
    .din   (chip_i),
    .q     (hist_q),
    .nxt   (hist_nxt)
  );

  sync2_cmp #(.W(PAT_W), .LEN_W(LEN_W)) u_cmp_a (
    .win (hist_nxt),
    .pat (pat_a_i),
    .len (len_a_i),
    .hit (hit_a_w)
  );

  sync2_cmp #(.W(PAT_W), .LEN_W(LEN_W)) u_cmp_b (
    .win (hist_nxt),
    .pat (pat_b_i),
    .len (len_b_i),
    .hit (hit_b_w)
  );

  sync2_ctrl #(.GAP_W(GAP_W), .LEN_W(LEN_W), .OFS(OFS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .vld      (chip_vld_i),
    .rearm    (rearm_i),
    .hit_a    (hit_a_w),
    .hit_b    (hit_b_w),
    .gap_len  (gap_len_i),
    .len_b    (len_b_i),
    .shift_en (shift_w),
    .clr      (clr_w),
    .match_a  (match_a_o),
    .resync   (resync_o),
    .tvalid   (tvalid_o)
  );

endmodule

// File: rtl/sync2_detect_chk.sv
module sync2_detect_chk #(
  parameter int PAT_W = 16,
  parameter int GAP_W = 8,
  parameter int OFS   = 6,
  parameter int LEN_W = $clog2(PAT_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             chip_i,
  input logic             chip_vld_i,
  input logic             rearm_i,
  input logic [PAT_W-1:0] pat_a_i,
  input logic [LEN_W-1:0] len_a_i,
  input logic [PAT_W-1:0] pat_b_i,
  input logic [LEN_W-1:0] len_b_i,
  input logic [GAP_W-1:0] gap_len_i,
  input logic             match_a_o,
  input logic             resync_o,
  input logic             tvalid_o
);

  // Independent strobe count since the last lead match, plus a held flag.
  logic        armed, held;
  logic [15:0] n_chip;
  logic        any_out;

  assign any_out = match_a_o || resync_o || tvalid_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      held   <= 1'b0;
      n_chip <= '0;
    end else begin
      if (match_a_o) begin
        armed  <= 1'b1;
        n_chip <= chip_vld_i ? 16'd1 : 16'd0;
      end else if (armed && chip_vld_i) begin
        n_chip <= n_chip + 16'd1;
      end
      if (tvalid_o)     held <= 1'b1;
      else if (rearm_i) held <= 1'b0;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !any_out);

  a_r9_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({match_a_o, resync_o, tvalid_o}));

  a_r9_after_strobe: assert property (@(posedge clk) disable iff (rst)
    any_out |-> $past(chip_vld_i));

  a_r3_resync_at_gap_end: assert property (@(posedge clk) disable iff (rst)
    resync_o |-> (armed && int'(n_chip) == int'(gap_len_i)));

  a_r5_valid_in_window: assert property (@(posedge clk) disable iff (rst)
    tvalid_o |-> (armed && int'(n_chip) >= int'(gap_len_i) + OFS
                  && int'(n_chip) <= int'(gap_len_i) + int'(len_b_i) + 11));

  a_r8_silent_while_held: assert property (@(posedge clk) disable iff (rst)
    held |-> !any_out);

endmodule

bind sync2_detect sync2_detect_chk #(
  .PAT_W(PAT_W), .GAP_W(GAP_W), .OFS(OFS), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/sync2_detect_bench.sv
module sync2_detect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OFS_B      = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip = 1'b0, vld = 1'b0, rearm = 1'b0;
  logic [15:0] pa = '0, pb = '0;
  logic [4:0]  la = 5'd1, lb = 5'd1;
  logic [7:0]  gp = 8'd1;
  logic        ma, rs, tv;

  int checks = 0, failures = 0;
  bit last_ma, last_rs, last_tv;

  // Bench model state: 0 hunt, 1 after lead, 2 held.
  int          md = 0, cnt = 0;
  logic [15:0] h = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync2_detect #(.PAT_W(16), .GAP_W(8), .OFS(OFS_B)) u_sync2_detect (
    .clk(clk), .rst(rst), .chip_i(chip), .chip_vld_i(vld), .rearm_i(rearm),
    .pat_a_i(pa), .len_a_i(la), .pat_b_i(pb), .len_b_i(lb), .gap_len_i(gp),
    .match_a_o(ma), .resync_o(rs), .tvalid_o(tv)
  );

  function automatic logic [15:0] lmask(input int len);
    logic [15:0] m = '0;
    for (int i = 0; i < 16; i++) if (i < len) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int first_cmp(input int g);
    return OFS_B + g;
  endfunction

  function automatic int close_pos(input int g, input int l);
    return 11 + l + g;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_chip(input bit c, output bit ema, output bit ers, output bit etv);
    ema = 0; ers = 0; etv = 0;
    if (md == 0) begin
      h = {h[14:0], c};
      if (((h ^ pa) & lmask(int'(la))) == 16'd0) begin
        ema = 1; md = 1; cnt = 0;
      end
    end else if (md == 1) begin
      cnt++;
      if (cnt == int'(gp)) begin
        ers = 1; h = '0;
      end else if (cnt >= first_cmp(int'(gp))) begin
        h = {h[14:0], c};
        if (((h ^ pb) & lmask(int'(lb))) == 16'd0) begin
          etv = 1; md = 2;
        end else if (cnt >= close_pos(int'(gp), int'(lb))) begin
          md = 0; h = '0;
        end
      end
    end
  endtask

  task automatic send(input bit c);
    bit ema, ers, etv;
    @(negedge clk);
    chip = c; vld = 1'b1;
    model_chip(c, ema, ers, etv);
    @(negedge clk);
    vld = 1'b0;
    last_ma = ma; last_rs = rs; last_tv = tv;
    chk(ma == ema, "R2 match_a", int'(ma), int'(ema));
    chk(rs == ers, "R3 resync", int'(rs), int'(ers));
    chk(tv == etv, "R5 tvalid", int'(tv), int'(etv));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({ma, rs, tv} == 3'b000, "R9 idle cycle outputs", int'({ma, rs, tv}), 0);
    end
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1'b1;
    if (md == 2) begin md = 0; h = '0; end
    @(negedge clk);
    rearm = 1'b0;
    chk({ma, rs, tv} == 3'b000, "R8 rearm outputs", int'({ma, rs, tv}), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    md = 0; cnt = 0; h = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk({ma, rs, tv} == 3'b000, "R1 outputs after reset", int'({ma, rs, tv}), 0);
  endtask

  task automatic send_a();
    for (int i = int'(la) - 1; i >= 0; i--) send(pa[i]);
  endtask

  task automatic send_b();
    for (int i = int'(lb) - 1; i >= 0; i--) send(pb[i]);
  endtask

  task automatic send_gap();
    for (int i = 1; i <= int'(gp); i++) begin
      send(1'($urandom % 2));
      if (i < int'(gp)) chk(!last_rs, "R3 no early resync", int'(last_rs), 0);
      else              chk(last_rs, "R3 resync on last gap chip", int'(last_rs), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    la = 5'd8; pa = 16'h00B4; gp = 8'd10; lb = 5'd5; pb = 16'h0013;
    do_reset();

    // Earliest trailer: begins on the first compared chip (R5).
    send_a();
    chk(last_ma, "R2 lead match on last lead chip", int'(last_ma), 1);
    send_gap();
    for (int i = 0; i < OFS_B - 1; i++) send(1'($urandom % 2));
    send_b();
    chk(last_tv, "R5 earliest trailer accepted", int'(last_tv), 1);

    // Held state: lead ignored until rearm (R8).
    send_a();
    chk(!last_ma, "R8 lead ignored while held", int'(last_ma), 0);
    do_rearm();
    send_a();
    chk(last_ma, "R8 lead found after rearm", int'(last_ma), 1);

    // Rearm inside the gap has no effect (R8); latest trailer (R5).
    send(1'b0);
    do_rearm();
    for (int i = 2; i <= int'(gp); i++) send(1'b0);
    chk(last_rs, "R8 rearm ignored in gap, resync on time", int'(last_rs), 1);
    for (int i = 0; i < 11; i++) send(1'b0);
    send_b();
    chk(last_tv, "R5 trailer ending on window close accepted", int'(last_tv), 1);
    do_rearm();

    // One chip late: refused, then lead hunt resumes (R7).
    send_a();
    send_gap();
    seen = 0;
    for (int i = 0; i < 12; i++) send(1'b0);
    for (int i = int'(lb) - 1; i >= 0; i--) begin
      send(pb[i]);
      if (last_tv) seen++;
    end
    chk(seen == 0, "R7 late trailer refused", seen, 0);
    send_a();
    chk(last_ma, "R7 lead hunt resumes after timeout", int'(last_ma), 1);

    // Skipped chips are never compared (R4): filler ends with trailer head.
    send_gap();
    send(1'b0); send(1'b0); send(1'b0); send(1'b1); send(1'b0);
    send(1'b0); send(1'b1); send(1'b1);
    chk(!last_tv, "R4 skipped chips not compared", int'(last_tv), 0);
    for (int i = 0; i < 20; i++) send(1'b0);

    // All-zero trailer matches at once on a cleared history (R6).
    pb = 16'h0000; lb = 5'd4;
    send_a();
    send_gap();
    for (int i = 0; i < OFS_B - 1; i++) send(1'b1);
    send(1'b0);
    chk(last_tv, "R6 all-zero trailer hits on first compared chip", int'(last_tv), 1);
    do_rearm();

    // Reset in the middle of a lead pattern (R1).
    for (int i = int'(la) - 1; i >= 1; i--) send(pa[i]);
    do_reset();
    send(pa[0]);
    chk(!last_ma, "R1 history cleared by reset", int'(last_ma), 0);

    // Random streams with short patterns (R2, R3, R5, R7, R9).
    for (int it = 0; it < 4000; it++) begin
      int r;
      if (md == 2 || it == 0) begin
        do_rearm();
        la = 5'(2 + $urandom % 5);
        pa = 16'($urandom) & lmask(int'(la));
        gp = 8'(1 + $urandom % 12);
        lb = 5'(1 + $urandom % 5);
        pb = (16'($urandom) & lmask(int'(lb))) | (16'd1 << (int'(lb) - 1));
      end
      r = int'($urandom % 10);
      if (r == 0)      send_a();
      else if (r == 1) send_b();
      else if (r == 2) idle(1 + int'($urandom % 3));
      else             send(1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule